// File: doc/BRIEF.md
# SPI Flash Page-Program Write Engine

This block drives a serial NOR flash through one page-program transaction at a time, under control of a simple register-write port. Software first stores an opcode, a three- or four-byte flash address and the payload. The payload is either one byte in a byte register, or a full page of `PAGE_BYTES` bytes pushed into an internal buffer as `WORD_W`-bit words. Software then sets the go bit of the command register. The engine emits the opcode, the address and the payload on a single output line and frames them with chip select. It clears the go bit, seen as `busy_o`, once the frame has ended.

Payload mode is chosen by a buffer-enable setting. That setting reaches the datapath only after a fixed pipeline delay. Software must watch `wbuf_active_o` until it shows the new value before it starts a write that depends on it. A write started while the buffer is active carries the whole page. A write started while it is inactive carries exactly one byte.

The serial sequencer is a five-state machine. IDLE keeps chip select high and waits for a go request. LEAD asserts chip select for one cycle with the first bit on the line. HIGH holds the serial clock high for `CLK_HALF` cycles. LOW holds it low for `CLK_HALF` cycles and presents the next bit. TAIL keeps chip select low with the clock low for `CLK_HALF` cycles after the last bit. The transitions are:
- IDLE→LEAD on go.
- LEAD→HIGH after one cycle.
- HIGH→LOW at the end of a half period when bits remain.
- HIGH→TAIL at the end of the half period of the final bit.
- LOW→HIGH at the end of a half period.
- TAIL→IDLE at the end of its half period. This step also ends the busy flag.

Top module: `spi_page_prog`

## Requirements
- R1: A write with `reg_sel`=0 and bit 4 of `reg_wdata` set, made while idle, raises `busy_o` in the next cycle. `busy_o` stays high for the whole frame and falls when chip select rises again. Chip select is never low while `busy_o` is low.
- R2: A frame carries, most significant bit first, the opcode (`reg_sel`=1), then the address bytes, then the payload. With bit 4 of the bus setting (`reg_sel`=6) clear, the address bytes are `reg_sel`=4, 3, 2. With that bit set, they are `reg_sel`=5, 4, 3, 2. Registers 2 to 5 hold the address from its least significant byte upwards.
- R3: A write started while `wbuf_active_o` is low carries exactly one payload byte, the low 8 bits last written to `reg_sel`=7. The upper bits of that write are discarded.
- R4: A write started while `wbuf_active_o` is high carries exactly `PAGE_BYTES` payload bytes from the buffer. Each word written with `reg_sel`=9 supplies four bytes, its bits 7:0 first in page order, and successive words follow in page order.
- R5: Bit 0 of a write to `reg_sel`=8 sets the buffer enable. `wbuf_active_o` takes the new value exactly `EN_DELAY` cycles after the cycle that accepted the write.
- R6: Chip select falls exactly one cycle before the first rising serial-clock edge. The serial clock is low whenever chip select is high, and chip select is high out of reset.
- R7: The data line changes only while the serial clock is low, so it is stable across every high phase.
- R8: A buffer word write made while `busy_o` is high leaves the buffer and its fill position unchanged.
- R9: When a buffered write completes, the fill position returns to the start of the page, even after a partial fill.
- R10: A frame contains exactly 8 × (1 + address bytes + payload bytes) rising serial-clock edges.
- R11: Out of reset, `busy_o` and `wbuf_active_o` are low, chip select is high and the serial clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register select (0 command, 1 opcode, 2–5 address bytes, 6 bus setting, 7 byte payload, 8 buffer enable, 9 page word) |
| reg_wdata | input | WORD_W | Register write data |
| busy_o | output | 1 | Readback of the command go bit |
| wbuf_active_o | output | 1 | Readback of the applied buffer enable |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |

## Verification
The bound checker watches the framing rules on every cycle: the clock only pulses inside chip select, chip select leads the first clock edge by one cycle, the data line is held through each high phase, chip select never appears without `busy_o`, and every frame closes on a whole number of bytes. Whether the bytes are the right ones cannot be seen by a property. That covers the opcode and address order, the page packing, one byte against a full page, the dropped word writes during a frame, the rewound fill position and the enable delay. These are shown only by the bench's scenarios, which decode the serial stream as a flash would and compare it with the expected frame.

// File: rtl/spp_pkg.sv
package spp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_TAIL
    } ser_state_t;

    localparam logic [3:0] SEL_CMD    = 4'd0;
    localparam logic [3:0] SEL_OPCODE = 4'd1;
    localparam logic [3:0] SEL_ADDR0  = 4'd2;
    localparam logic [3:0] SEL_ADDR1  = 4'd3;
    localparam logic [3:0] SEL_ADDR2  = 4'd4;
    localparam logic [3:0] SEL_ADDR3  = 4'd5;
    localparam logic [3:0] SEL_BUSCFG = 4'd6;
    localparam logic [3:0] SEL_WBYTE  = 4'd7;
    localparam logic [3:0] SEL_BUFCFG = 4'd8;
    localparam logic [3:0] SEL_PAGE   = 4'd9;

    localparam int GO_BIT     = 4;
    localparam int ADDR4_BIT  = 4;
    localparam int BUF_EN_BIT = 0;

endpackage

// File: rtl/spp_page_buf.sv
module spp_page_buf #(
    parameter int PAGE_BYTES = 128,
    parameter int WORD_W     = 32,
    localparam int BPW       = WORD_W / 8,
    localparam int WORDS     = PAGE_BYTES / BPW,
    localparam int IDX_W     = $clog2(PAGE_BYTES),
    localparam int LANE_W    = $clog2(BPW),
    localparam int PTR_W     = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              ptr_clr,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [7:0]        rd_byte
);

    logic [WORD_W-1:0] mem_q [WORDS];
    logic [PTR_W-1:0]  wptr_q;
    logic [WORD_W-1:0] rd_word;
    logic [7:0]        lanes [BPW];

    // Fill position: advances per accepted word, rewinds on request.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
        end else if (ptr_clr) begin
            wptr_q <= '0;
        end else if (wr_en) begin
            wptr_q <= wptr_q + PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !ptr_clr) begin
            mem_q[wptr_q] <= wr_data;
        end
    end

    assign rd_word = mem_q[rd_idx[IDX_W-1:LANE_W]];

    // Byte lanes: lane 0 is the earliest byte of each word.
    for (genvar g = 0; g < BPW; g++) begin : g_lane
        assign lanes[g] = rd_word[g*8 +: 8];
    end

    assign rd_byte = lanes[rd_idx[LANE_W-1:0]];

endmodule

// File: rtl/spp_serializer.sv
module spp_serializer
    import spp_pkg::*;
#(
    parameter int PAGE_BYTES = 128,
    parameter int CLK_HALF   = 2,
    localparam int FRAME_W   = $clog2(PAGE_BYTES + 6),
    localparam int DIV_W     = $clog2(CLK_HALF + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               addr4,
    input  logic               buffered,
    input  logic [7:0]         byte_in,
    output logic [FRAME_W-1:0] byte_idx,
    output logic               sck,
    output logic               cs_n,
    output logic               mosi,
    output logic               done
);

    ser_state_t         state_q;
    logic [DIV_W-1:0]   div_q;
    logic [2:0]         bit_q;
    logic [FRAME_W-1:0] byte_q;
    logic [FRAME_W-1:0] last_q;
    logic               half_end;

    assign half_end = (div_q == DIV_W'(CLK_HALF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            div_q   <= '0;
            bit_q   <= '0;
            byte_q  <= '0;
            last_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_LEAD;
                        div_q   <= '0;
                        bit_q   <= '0;
                        byte_q  <= '0;
                        last_q  <= FRAME_W'(addr4 ? 4 : 3)
                                 + (buffered ? FRAME_W'(PAGE_BYTES) : FRAME_W'(1));
                    end
                end
                ST_LEAD: begin
                    state_q <= ST_HIGH;
                    div_q   <= '0;
                end
                ST_HIGH: begin
                    if (half_end) begin
                        div_q <= '0;
                        if (bit_q == 3'd7 && byte_q == last_q) begin
                            state_q <= ST_TAIL;
                        end else begin
                            state_q <= ST_LOW;
                            bit_q   <= bit_q + 3'd1;
                            if (bit_q == 3'd7) begin
                                byte_q <= byte_q + FRAME_W'(1);
                            end
                        end
                    end else begin
                        div_q <= div_q + DIV_W'(1);
                    end
                end
                ST_LOW: begin
                    if (half_end) begin
                        div_q   <= '0;
                        state_q <= ST_HIGH;
                    end else begin
                        div_q <= div_q + DIV_W'(1);
                    end
                end
                ST_TAIL: begin
                    if (half_end) begin
                        div_q   <= '0;
                        state_q <= ST_IDLE;
                    end else begin
                        div_q <= div_q + DIV_W'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        sck      = (state_q == ST_HIGH);
        cs_n     = (state_q == ST_IDLE);
        mosi     = (state_q != ST_IDLE) ? byte_in[3'd7 - bit_q] : 1'b0;
        done     = (state_q == ST_TAIL) && half_end;
        byte_idx = byte_q;
    end

endmodule

// File: rtl/spi_page_prog.sv
module spi_page_prog
    import spp_pkg::*;
#(
    parameter int PAGE_BYTES = 128,
    parameter int WORD_W     = 32,
    parameter int CLK_HALF   = 2,
    parameter int EN_DELAY   = 3,
    localparam int FRAME_W   = $clog2(PAGE_BYTES + 6),
    localparam int IDX_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [3:0]        reg_sel,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic              busy_o,
    output logic              wbuf_active_o,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic              spi_mosi
);

    logic [7:0]          opcode_q;
    logic [7:0]          wbyte_q;
    logic [7:0]          addr_q [4];
    logic                addr4_q;
    logic                buf_req_q;
    logic                busy_q;
    logic                snap_addr4_q;
    logic                snap_buf_q;
    logic [EN_DELAY-1:0] en_pipe_q;

    logic               start;
    logic               done;
    logic [FRAME_W-1:0] byte_idx;
    logic [7:0]         cur_byte;
    logic [7:0]         page_byte;
    logic [IDX_W-1:0]   page_idx;
    logic               page_wr;

    assign start   = reg_wr && (reg_sel == SEL_CMD) && reg_wdata[GO_BIT] && !busy_q;
    assign page_wr = reg_wr && (reg_sel == SEL_PAGE) && !busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opcode_q     <= '0;
            wbyte_q      <= '0;
            addr_q       <= '{default: '0};
            addr4_q      <= 1'b0;
            buf_req_q    <= 1'b0;
            busy_q       <= 1'b0;
            snap_addr4_q <= 1'b0;
            snap_buf_q   <= 1'b0;
        end else begin
            if (reg_wr) begin
                case (reg_sel)
                    SEL_OPCODE: opcode_q  <= reg_wdata[7:0];
                    SEL_ADDR0:  addr_q[0] <= reg_wdata[7:0];
                    SEL_ADDR1:  addr_q[1] <= reg_wdata[7:0];
                    SEL_ADDR2:  addr_q[2] <= reg_wdata[7:0];
                    SEL_ADDR3:  addr_q[3] <= reg_wdata[7:0];
                    SEL_BUSCFG: addr4_q   <= reg_wdata[ADDR4_BIT];
                    SEL_WBYTE:  wbyte_q   <= reg_wdata[7:0];
                    SEL_BUFCFG: buf_req_q <= reg_wdata[BUF_EN_BIT];
                    default: ;
                endcase
            end
            if (start) begin
                busy_q       <= 1'b1;
                snap_addr4_q <= addr4_q;
                snap_buf_q   <= wbuf_active_o;
            end else if (done) begin
                busy_q <= 1'b0;
            end
        end
    end

    // Buffer-enable settle pipeline; depth picks the variant.
    if (EN_DELAY == 1) begin : g_en_one
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) en_pipe_q <= '0;
            else        en_pipe_q <= buf_req_q;
        end
    end else begin : g_en_chain
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) en_pipe_q <= '0;
            else        en_pipe_q <= {en_pipe_q[EN_DELAY-2:0], buf_req_q};
        end
    end

    assign wbuf_active_o = en_pipe_q[EN_DELAY-1];
    assign busy_o        = busy_q;

    // Frame byte source: opcode, address (high byte first), payload.
    always_comb begin
        page_idx = IDX_W'(byte_idx - (snap_addr4_q ? FRAME_W'(5) : FRAME_W'(4)));
        if (byte_idx == '0) begin
            cur_byte = opcode_q;
        end else if (byte_idx <= (snap_addr4_q ? FRAME_W'(4) : FRAME_W'(3))) begin
            cur_byte = addr_q[2'((snap_addr4_q ? FRAME_W'(4) : FRAME_W'(3)) - byte_idx)];
        end else begin
            cur_byte = snap_buf_q ? page_byte : wbyte_q;
        end
    end

    spp_page_buf #(
        .PAGE_BYTES (PAGE_BYTES),
        .WORD_W     (WORD_W)
    ) page_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (page_wr),
        .wr_data (reg_wdata),
        .ptr_clr (done && snap_buf_q),
        .rd_idx  (page_idx),
        .rd_byte (page_byte)
    );

    spp_serializer #(
        .PAGE_BYTES (PAGE_BYTES),
        .CLK_HALF   (CLK_HALF)
    ) ser_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .addr4    (addr4_q),
        .buffered (wbuf_active_o),
        .byte_in  (cur_byte),
        .byte_idx (byte_idx),
        .sck      (spi_sck),
        .cs_n     (spi_cs_n),
        .mosi     (spi_mosi),
        .done     (done)
    );

endmodule

// File: rtl/spp_checker.sv
module spp_checker (
    input logic clk,
    input logic rst_n,
    input logic busy_o,
    input logic spi_sck,
    input logic spi_cs_n,
    input logic spi_mosi
);

    logic [15:0] edge_cnt_q;
    logic        sck_q;
    logic        cs_n_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_cnt_q <= '0;
            sck_q      <= 1'b0;
            cs_n_q     <= 1'b1;
        end else begin
            sck_q  <= spi_sck;
            cs_n_q <= spi_cs_n;
            if (!spi_cs_n && cs_n_q) begin
                edge_cnt_q <= '0;
            end else if (spi_sck && !sck_q) begin
                edge_cnt_q <= edge_cnt_q + 16'd1;
            end
        end
    end

    assert_sck_inside_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |-> !spi_cs_n);

    assert_cs_lead_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> !spi_sck ##1 spi_sck);

    assert_mosi_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

    assert_cs_needs_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> busy_o);

    assert_whole_bytes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> (edge_cnt_q[2:0] == 3'd0 && edge_cnt_q >= 16'd40));

endmodule

bind spi_page_prog spp_checker chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy_o   (busy_o),
    .spi_sck  (spi_sck),
    .spi_cs_n (spi_cs_n),
    .spi_mosi (spi_mosi)
);

// File: tb/spi_page_prog_tb.sv
module spi_page_prog_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int PAGE       = 128;
    localparam int EN_DELAY   = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic        busy_o, wbuf_active_o, spi_sck, spi_cs_n, spi_mosi;

    int checks = 0;
    int fails  = 0;

    logic [7:0] cap [256];
    logic [7:0] expv [256];
    int         ncap = 0, nbits = 0, nlead = 0;
    logic       prev_sck = 1'b0;
    logic [7:0] shreg = '0;

    spi_page_prog #(.PAGE_BYTES(PAGE), .WORD_W(32), .CLK_HALF(2), .EN_DELAY(EN_DELAY)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .busy_o(busy_o), .wbuf_active_o(wbuf_active_o),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Flash model: captures one bit per rising serial-clock edge.
    always @(negedge clk) begin
        if (rst_n && !spi_cs_n) begin
            if (spi_sck && !prev_sck) begin
                shreg = {shreg[6:0], spi_mosi};
                nbits++;
                if (nbits % 8 == 0 && ncap < 256) begin
                    cap[ncap] = shreg;
                    ncap++;
                end
            end else if (!spi_sck && nbits == 0) begin
                nlead++;
            end
        end
        prev_sck = spi_sck;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    function automatic logic [7:0] pat(input int i, input int seed);
        return 8'((i * seed + 3) & 8'hFF);
    endfunction

    task automatic fill_words(input int first, input int count, input int seed);
        for (int k = first; k < first + count; k++) begin
            wr(4'd9, {pat(4*k+3, seed), pat(4*k+2, seed), pat(4*k+1, seed), pat(4*k, seed)});
        end
    endtask

    task automatic launch(input bit poke_busy);
        ncap = 0; nbits = 0; nlead = 0;
        wr(4'd0, 32'h10);
        check(busy_o == 1'b1, "R1 busy after go", busy_o, 1);
        if (poke_busy) wr(4'd9, 32'hDEADBEEF); // R8: must be dropped
        for (int t = 0; t < 20000 && busy_o; t++) @(negedge clk);
        check(busy_o == 1'b0, "R1 busy cleared", busy_o, 0);
        check(spi_cs_n == 1'b1, "R6 cs high after frame", spi_cs_n, 1);
    endtask

    task automatic check_frame(input int n, input string req);
        check(ncap == n, req, ncap, n);
        check(nbits == n * 8, "R10 clock edge count", nbits, n * 8);
        check(nlead == 1, "R6 one-cycle lead", nlead, 1);
        for (int i = 0; i < n && i < 256; i++)
            check(cap[i] == expv[i], req, cap[i], expv[i]);
    endtask

    task automatic t_reset;
        check(spi_cs_n == 1'b1, "R11 cs", spi_cs_n, 1);
        check(spi_sck == 1'b0, "R11 sck", spi_sck, 0);
        check(busy_o == 1'b0, "R11 busy", busy_o, 0);
        check(wbuf_active_o == 1'b0, "R11 wbuf", wbuf_active_o, 0);
    endtask

    task automatic t_single3;
        wr(4'd1, 32'h02); wr(4'd2, 32'h56); wr(4'd3, 32'h34); wr(4'd4, 32'h12);
        wr(4'd6, 32'h00); wr(4'd7, 32'hA5);
        launch(1'b0);
        expv[0] = 8'h02; expv[1] = 8'h12; expv[2] = 8'h34; expv[3] = 8'h56; expv[4] = 8'hA5;
        check_frame(5, "R2 R3 single 3-byte frame");
    endtask

    task automatic t_single4;
        wr(4'd5, 32'h9A); wr(4'd6, 32'h10); wr(4'd7, 32'h0000_773C);
        launch(1'b0);
        expv[0] = 8'h02; expv[1] = 8'h9A; expv[2] = 8'h12; expv[3] = 8'h34;
        expv[4] = 8'h56; expv[5] = 8'h3C;
        check_frame(6, "R2 R3 single 4-byte frame");
    endtask

    task automatic t_enable(input bit val);
        int n = 0;
        wr(4'd8, {31'd0, val});
        check(wbuf_active_o == !val, "R5 enable not yet applied", wbuf_active_o, !val);
        while (wbuf_active_o != val && n < 50) begin
            @(negedge clk); n++;
        end
        check(n == EN_DELAY, "R5 enable delay", n, EN_DELAY);
    endtask

    task automatic t_page_full;
        wr(4'd6, 32'h00);
        fill_words(0, PAGE/4, 7);
        launch(1'b1);
        expv[0] = 8'h02; expv[1] = 8'h12; expv[2] = 8'h34; expv[3] = 8'h56;
        for (int i = 0; i < PAGE; i++) expv[4+i] = pat(i, 7);
        check_frame(4 + PAGE, "R4 R8 buffered page");
    endtask

    task automatic t_page_partial;
        wr(4'd6, 32'h10);
        fill_words(0, 5, 11);
        launch(1'b0);
        expv[0] = 8'h02; expv[1] = 8'h9A; expv[2] = 8'h12; expv[3] = 8'h34; expv[4] = 8'h56;
        for (int i = 0; i < PAGE; i++) expv[5+i] = (i < 20) ? pat(i, 11) : pat(i, 7);
        check_frame(5 + PAGE, "R4 partial page 4-byte");
    endtask

    task automatic t_page_rewind;
        fill_words(0, PAGE/4, 13);
        launch(1'b0);
        for (int i = 0; i < PAGE; i++) expv[5+i] = pat(i, 13);
        check_frame(5 + PAGE, "R9 fill position rewound");
    endtask

    task automatic t_back_to_single;
        wr(4'd7, 32'h81);
        launch(1'b0);
        expv[5] = 8'h81;
        check_frame(6, "R3 R5 single after disable");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single3();
        t_single4();
        t_enable(1'b1);
        t_page_full();
        t_page_partial();
        t_page_rewind();
        t_enable(1'b0);
        t_back_to_single();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++; fails++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule